// File: doc/BRIEF.md
# Cascaded Fly-By DMA Arbiter

This block decides which of eight DMA channels owns the system bus and then runs that channel's transfers without the CPU taking part. The channels come from two four-channel controllers. The upper controller gives one of its own request positions to the lower controller, so that position carries the whole lower group, and devices can request on seven channels. The lower group (channels 0 to 3) moves bytes. The upper group (channels 5 to 7) moves 16-bit words. Channel 4 is the cascade position and cannot be requested.

Software sets up a channel by writing a start address, a transfer count and a direction, and that write arms the channel. An armed channel whose device raises its request causes the block to ask the CPU for the bus. Once the CPU grants the bus, the block runs one fly-by bus cycle per clock for the winning channel. In each such cycle it drives the memory address, the device acknowledge and one read strobe on one side with one write strobe on the other side. The data goes directly between device and memory and is never held inside the block. After the last transfer the channel disarms itself and reports terminal count. When no armed channel requests any more, the block gives the bus back.

Top module: `cdma_flyby_arb`

## Requirements
- R1: After reset, every channel is disarmed. `hrq`, `dack`, all four strobes and `tc` are low. Requests on channels that have not been programmed are ignored.
- R2: A clock edge that sees a request on an armed channel sets `hrq` high after that edge. No acknowledge or strobe appears at that edge.
- R3: A transfer is issued at an edge where `hrq` is already high, `hlda` is high and an armed channel requests. After that edge, for one cycle, `dack` is one-hot on the winner and `bus_addr` shows the winner's current address. When `cfg_to_mem`=1 the strobes are `io_rd`=1 and `mem_wr`=1. When `cfg_to_mem`=0 they are `mem_rd`=1 and `io_wr`=1. The strobes not named are 0.
- R4: Priority is fixed by channel number, lowest number first. The lower group enters the upper group's arbitration at the cascade position, so the effective order is 0, 1, 2, 3, 5, 6, 7.
- R5: After each transfer the channel's address advances by 1 on channels 0 to 3 and by 2 on channels 5 to 7.
- R6: A programmed count N gives N+1 transfers. The last of them is marked by `tc`=1 in the same cycle as its `dack`. The channel is then disarmed, and its request is ignored until it is programmed again.
- R7: Channel 4 is never acknowledged. Its request never raises `hrq`, and a configuration write that selects it has no effect.
- R8: `hrq` falls after the first edge at which no armed channel requests.
- R9: While `hlda` is low, no transfer is issued and `hrq` stays high. When `hlda` returns, transfers continue from the channel's current address.
- R10: The address counter wraps modulo 2^16. For example, 0xFFFF followed by a step of 1 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_we | input | 1 | Programs and arms the selected channel |
| cfg_sel | input | 3 | Channel number to program |
| cfg_base | input | 16 | Start address |
| cfg_count | input | 16 | Transfer count minus one |
| cfg_to_mem | input | 1 | 1: device to memory, 0: memory to device |
| dreq | input | 8 | Per-channel device request (bit 4 ignored) |
| hrq | output | 1 | Bus request to CPU |
| hlda | input | 1 | Bus grant from CPU |
| dack | output | 8 | Per-channel acknowledge, one-hot during a transfer |
| bus_addr | output | 16 | Memory address of the current transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| tc | output | 1 | Terminal count, with the last transfer |

## Verification
The bench holds `hlda` low while a request is pending. A design that drove the bus without the grant would show an acknowledge during that wait. The bench also drops the grant in the middle of a run, and a design that lost its place would resume from the wrong address. Five requests go up at once, including the cascade channel 4. A flat eight-way encoder would misplace the lower group or acknowledge channel 4. Wrong terminal-count handling would give an extra or missing transfer, or keep serving a channel after its last one. Word-channel runs across a 4 KiB boundary and a byte-channel run from 0xFFFF expose a wrong step size or a wrong wrap.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
   typedef enum logic {
      DIR_FROM_MEM = 1'b0,
      DIR_TO_MEM   = 1'b1
   } cdma_dir_e;

   // address increment for a channel: lower group byte-wide, upper group word-wide
   function automatic int unsigned chan_step(input int unsigned ch, input int unsigned per_ctrl);
      return (ch < per_ctrl) ? 1 : 2;
   endfunction
endpackage

// File: rtl/cdma_prio.sv
module cdma_prio #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   if (N < 2) begin : g_bad_n
      $error("cdma_prio: N must be at least 2");
   end

   // lowest index wins: isolate least significant set bit
   assign grant = req & (~req + N'(1));
   assign any   = |req;
endmodule

// File: rtl/cdma_chan.sv
module cdma_chan
   import cdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned STEP   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  count,
   input  cdma_dir_e         dir_in,
   input  logic              step_en,
   output logic              armed,
   output logic [ADDR_W-1:0] addr,
   output cdma_dir_e         dir,
   output logic              last
);
   localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

   logic [CNT_W-1:0] remain;

   if (STEP != 1 && STEP != 2) begin : g_bad_step
      $error("cdma_chan: STEP must be 1 or 2");
   end

   assign last = (remain == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         addr   <= '0;
         remain <= '0;
         dir    <= DIR_FROM_MEM;
      end else if (wr) begin
         armed  <= 1'b1;
         addr   <= base;
         remain <= count;
         dir    <= dir_in;
      end else if (step_en) begin
         addr   <= addr + INC;
         remain <= remain - CNT_W'(1);
         if (last) armed <= 1'b0;
      end
   end

   a_r6_disarm_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && last && !wr) |=> !armed);
   a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !wr) |=> (addr == $past(addr) + INC));
   a_r6_only_armed_steps: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |-> armed);
endmodule

// File: rtl/cdma_flyby_arb.sv
module cdma_flyby_arb
   import cdma_pkg::*;
#(
   parameter int unsigned PER_CTRL    = 4,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned CASCADE_POS = 0,
   localparam int unsigned NCH        = 2 * PER_CTRL,
   localparam int unsigned SEL_W      = $clog2(NCH),
   localparam int unsigned CASC_CH    = PER_CTRL + CASCADE_POS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              cfg_to_mem,
   input  logic [NCH-1:0]    dreq,
   output logic              hrq,
   input  logic              hlda,
   output logic [NCH-1:0]    dack,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic              tc
);
   if (CASCADE_POS >= PER_CTRL) begin : g_bad_casc
      $error("cdma_flyby_arb: CASCADE_POS outside the upper controller");
   end
   if (ADDR_W < 2 || CNT_W < 1) begin : g_bad_w
      $error("cdma_flyby_arb: address or count width too small");
   end

   logic [NCH-1:0]    armed, last, pending, grant, step_en;
   logic [ADDR_W-1:0] ch_addr [NCH];
   cdma_dir_e         ch_dir  [NCH];
   logic              issue;

   // per-channel state; the cascade position has none
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (i == CASC_CH) begin : g_casc
         assign armed[i]   = 1'b0;
         assign last[i]    = 1'b0;
         assign ch_addr[i] = '0;
         assign ch_dir[i]  = DIR_FROM_MEM;
      end else begin : g_real
         cdma_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .STEP   (chan_step(i, PER_CTRL))
         ) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (cfg_we && (cfg_sel == SEL_W'(i))),
            .base    (cfg_base),
            .count   (cfg_count),
            .dir_in  (cdma_dir_e'(cfg_to_mem)),
            .step_en (step_en[i]),
            .armed   (armed[i]),
            .addr    (ch_addr[i]),
            .dir     (ch_dir[i]),
            .last    (last[i])
         );
      end
   end

   assign pending = armed & dreq;

   // two-level fixed priority: lower group feeds one upper position
   logic [PER_CTRL-1:0] lo_grant, up_req, up_grant;
   logic                lo_any, up_any;

   cdma_prio #(.N(PER_CTRL)) lo_prio_i (
      .req   (pending[PER_CTRL-1:0]),
      .grant (lo_grant),
      .any   (lo_any)
   );

   for (genvar k = 0; k < PER_CTRL; k++) begin : g_up_req
      if (k == CASCADE_POS) begin : g_c
         assign up_req[k] = lo_any;
      end else begin : g_n
         assign up_req[k] = pending[PER_CTRL + k];
      end
   end

   cdma_prio #(.N(PER_CTRL)) up_prio_i (
      .req   (up_req),
      .grant (up_grant),
      .any   (up_any)
   );

   for (genvar k = 0; k < PER_CTRL; k++) begin : g_grant
      assign grant[k] = up_grant[CASCADE_POS] & lo_grant[k];
      if (k == CASCADE_POS) begin : g_c
         assign grant[PER_CTRL + k] = 1'b0;
      end else begin : g_n
         assign grant[PER_CTRL + k] = up_grant[k];
      end
   end

   assign issue   = hrq && hlda && up_any;
   assign step_en = issue ? grant : '0;

   // winner's address and direction
   logic [ADDR_W-1:0] sel_addr;
   logic              sel_to_mem, sel_last;
   always_comb begin
      sel_addr   = '0;
      sel_to_mem = 1'b0;
      sel_last   = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         sel_addr   = sel_addr | (ch_addr[i] & {ADDR_W{grant[i]}});
         sel_to_mem = sel_to_mem | (grant[i] && ch_dir[i] == DIR_TO_MEM);
         sel_last   = sel_last | (grant[i] && last[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hrq      <= 1'b0;
         dack     <= '0;
         bus_addr <= '0;
         mem_rd   <= 1'b0;
         mem_wr   <= 1'b0;
         io_rd    <= 1'b0;
         io_wr    <= 1'b0;
         tc       <= 1'b0;
      end else begin
         hrq      <= |pending;
         dack     <= step_en;
         bus_addr <= issue ? sel_addr : '0;
         mem_wr   <= issue && sel_to_mem;
         io_rd    <= issue && sel_to_mem;
         mem_rd   <= issue && !sel_to_mem;
         io_wr    <= issue && !sel_to_mem;
         tc       <= issue && sel_last;
      end
   end

   a_r3_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack));
   a_r3_strobe_pairing: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> ((mem_rd != mem_wr) && (io_rd == mem_wr) && (io_wr == mem_rd)));
   a_r3_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(|dack) |-> !(mem_rd || mem_wr || io_rd || io_wr || tc));
   a_r9_grant_needed: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> ($past(hlda) && $past(hrq)));
   a_r7_cascade_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !dack[CASC_CH]);
   a_r4_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

// File: tb/cdma_flyby_arb_tb_top.sv
module cdma_flyby_arb_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [15:0] cfg_base = '0;
   logic [15:0] cfg_count = '0;
   logic        cfg_to_mem = 1'b0;
   logic [7:0]  dreq = '0;
   logic        hlda = 1'b0;
   logic        hrq, mem_rd, mem_wr, io_rd, io_wr, tc;
   logic [7:0]  dack;
   logic [15:0] bus_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cdma_flyby_arb dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_base(cfg_base), .cfg_count(cfg_count), .cfg_to_mem(cfg_to_mem),
      .dreq(dreq), .hrq(hrq), .hlda(hlda), .dack(dack), .bus_addr(bus_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .tc(tc)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_idle(input string req, input logic exp_hrq);
      chk(req, "dack idle", 32'(dack), 32'h0);
      chk(req, "strobes idle", 32'({mem_rd, mem_wr, io_rd, io_wr, tc}), 32'h0);
      chk(req, "hrq", 32'(hrq), 32'(exp_hrq));
   endtask

   task automatic chk_x(input string req, input int ch, input logic [15:0] a, input logic to_mem, input logic exp_tc);
      chk(req, "dack", 32'(dack), 32'(8'(1) << ch));
      chk(req, "bus_addr", 32'(bus_addr), 32'(a));
      chk(req, "strobes {mrd,mwr,iord,iowr}", 32'({mem_rd, mem_wr, io_rd, io_wr}),
          to_mem ? 32'b0110 : 32'b1001);
      chk(req, "tc", 32'(tc), 32'(exp_tc));
   endtask

   task automatic prog(input int ch, input logic [15:0] base, input logic [15:0] cnt, input logic to_mem);
      cfg_we = 1'b1; cfg_sel = 3'(ch); cfg_base = base; cfg_count = cnt; cfg_to_mem = to_mem;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      chk_idle("R1", 1'b0);
      dreq = 8'hFF;
      tick(); tick();
      chk_idle("R1", 1'b0);   // nothing armed: requests ignored
      dreq = '0;
   endtask

   task automatic t_cascade_only();
      prog(4, 16'h4444, 16'd3, 1'b1);
      dreq = 8'h10; hlda = 1'b1;
      tick(); tick(); tick();
      chk_idle("R7", 1'b0);
      dreq = '0; hlda = 1'b0;
   endtask

   task automatic t_hold_and_tc();
      prog(1, 16'h0100, 16'd2, 1'b1);
      dreq = 8'h02;
      tick();
      chk_idle("R2", 1'b1);
      tick(); tick();
      chk_idle("R9", 1'b1);   // no grant yet
      hlda = 1'b1;
      tick(); chk_x("R3", 1, 16'h0100, 1'b1, 1'b0);
      tick(); chk_x("R5", 1, 16'h0101, 1'b1, 1'b0);
      tick(); chk_x("R6", 1, 16'h0102, 1'b1, 1'b1);
      chk("R8", "hrq during last", 32'(hrq), 32'h1);
      tick(); chk_idle("R8", 1'b0);
      tick(); chk_idle("R6", 1'b0);   // request still high, channel disarmed
      dreq = '0; hlda = 1'b0;
      tick();
   endtask

   task automatic t_hlda_drop();
      prog(5, 16'h0200, 16'd5, 1'b0);
      dreq = 8'h20; hlda = 1'b1;
      tick(); chk_idle("R2", 1'b1);
      tick(); chk_x("R3", 5, 16'h0200, 1'b0, 1'b0);
      tick(); chk_x("R5", 5, 16'h0202, 1'b0, 1'b0);
      hlda = 1'b0;
      tick(); chk_idle("R9", 1'b1);
      hlda = 1'b1;
      tick(); chk_x("R9", 5, 16'h0204, 1'b0, 1'b0);
      dreq = '0;
      tick(); chk_idle("R8", 1'b0);
      hlda = 1'b0;
   endtask

   task automatic t_priority();
      prog(0, 16'h0010, 16'd0, 1'b1);
      prog(2, 16'h0020, 16'd0, 1'b1);
      prog(5, 16'h0050, 16'd0, 1'b1);
      prog(7, 16'h0070, 16'd0, 1'b1);
      prog(4, 16'h0040, 16'd0, 1'b1);
      hlda = 1'b1;
      dreq = 8'b1011_0101;
      tick(); chk_idle("R2", 1'b1);
      tick(); chk_x("R4", 0, 16'h0010, 1'b1, 1'b1);
      tick(); chk_x("R4", 2, 16'h0020, 1'b1, 1'b1);
      tick(); chk_x("R4", 5, 16'h0050, 1'b1, 1'b1);
      tick(); chk_x("R4", 7, 16'h0070, 1'b1, 1'b1);
      tick(); chk_idle("R7", 1'b0);
      dreq = '0; hlda = 1'b0;
   endtask

   task automatic t_word_step();
      prog(6, 16'h0FFE, 16'd2, 1'b0);
      dreq = 8'h40; hlda = 1'b1;
      tick();
      for (int k = 0; k < 3; k++) begin
         tick();
         chk_x("R5", 6, 16'h0FFE + 16'(2 * k), 1'b0, k == 2);
      end
      tick(); chk_idle("R6", 1'b0);
      dreq = '0; hlda = 1'b0;
   endtask

   task automatic t_wrap();
      prog(3, 16'hFFFF, 16'd1, 1'b1);
      dreq = 8'h08; hlda = 1'b1;
      tick();
      tick(); chk_x("R10", 3, 16'hFFFF, 1'b1, 1'b0);
      tick(); chk_x("R10", 3, 16'h0000, 1'b1, 1'b1);
      dreq = '0; hlda = 1'b0;
      tick();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_cascade_only();
      t_hold_and_tc();
      t_hlda_drop();
      t_priority();
      t_word_step();
      t_wrap();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule